// File: doc/BRIEF.md
# Rotate-Right Execution Stage with Condition Flags

This block is the rotate-right stage of a small 16-bit coprocessor datapath. It reads a destination register from its own eight-entry register file, rotates that value right by an amount n, and writes the rotated word back to the same register. In the same cycle it updates a four-bit condition register. Bits rotated out at the bottom come back in at the top. The amount comes from one of two places, picked by a mode input. It is either a 4-bit immediate supplied with the operation or the low nibble of a second, source register.

The stage finishes one operation per clock. A single execute strobe commits both the write-back and the flag update. A separate load port lets neighbouring units place results in the register file and in the flags. A read port lets them observe any register. The rotated value is also available on its own combinational output before it is committed.

Top module: `rotu_exec`

## Requirements
- R1: `result` equals the selected destination register rotated right by n positions, so the low n bits appear in the top n positions. On a clock edge with `exec_en` high, this value is written back into the destination register.
- R2: With `amt_mode` = 0 (immediate mode), n is `imm_amt`.
- R3: With `amt_mode` = 1 (register mode), n is bits [3:0] of the source register selected by `src_idx`. Bits [15:4] of that register have no effect on the result.
- R4: When n is zero, the destination is written back unchanged, and the flags are still updated.
- R5: The flags are packed as `flags[3]` = N, `flags[2]` = Z, `flags[1]` = V and `flags[0]` = C. After an execute edge, N equals bit 15 of the rotated result.
- R6: After an execute edge, Z is 1 exactly when the rotated result is 0x0000.
- R7: An execute edge always clears V.
- R8: An execute edge never modifies C. It keeps the value it held before the edge.
- R9: Register 0 always reads as zero. Writes to it, through either the load port or the execute write-back, are ignored.
- R10: On an edge where `exec_en`, `ld_en` and `ccr_ld_en` are all low, neither the registers nor the flags change.
- R11: A synchronous active-high `rst` clears all registers and all four flags.
- R12: `ld_en` writes `ld_data` into register `ld_idx`. `ccr_ld_en` loads `ccr_ld_val` into the flags. If an execute operation targets the same register, the execute write-back takes precedence. `ccr_ld_en` is ignored while `exec_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Commit the rotate on this edge |
| amt_mode | input | 1 | 0: immediate amount, 1: source-register amount |
| dst_idx | input | 3 | Destination register index |
| src_idx | input | 3 | Source register index (amount nibble) |
| imm_amt | input | 4 | Immediate rotate amount |
| ld_en | input | 1 | Load-port write enable |
| ld_idx | input | 3 | Load-port register index |
| ld_data | input | 16 | Load-port write data |
| ccr_ld_en | input | 1 | Flag load enable |
| ccr_ld_val | input | 4 | Flag load value {N,Z,V,C} |
| obs_idx | input | 3 | Observation read index |
| result | output | 16 | Rotated value of the destination register |
| flags | output | 4 | Condition register {N,Z,V,C} |
| obs_data | output | 16 | Contents of register `obs_idx` |

## Verification
The assertions check the flag rules on every execute edge. They confirm that N and Z follow the committed result, that V is cleared and that C keeps its prior value. On every cycle they also check that register 0 reads zero and that idle edges leave the flags unchanged. Other behaviour appears only in the bench's scenarios. These are the exact rotation pattern for every amount in both modes, the fact that the high source bits do not matter, the write-back of an unchanged word at n = 0, and the write priority between the execute path and the load port.

// File: rtl/rotu_pkg.sv
`timescale 1ns/1ps
package rotu_pkg;
   typedef enum logic {
      AMT_IMM = 1'b0,
      AMT_REG = 1'b1
   } amt_mode_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

   localparam int CCR_W = 4;
endpackage

// File: rtl/rotu_regfile.sv
`timescale 1ns/1ps
module rotu_regfile #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int IW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] ra_idx,
   output logic [DW-1:0] ra_data,
   input  logic [IW-1:0] rb_idx,
   output logic [DW-1:0] rb_data,
   input  logic [IW-1:0] rc_idx,
   output logic [DW-1:0] rc_data,
   input  logic          wa_en,
   input  logic [IW-1:0] wa_idx,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [IW-1:0] wb_idx,
   input  logic [DW-1:0] wb_data
);
   logic [DW-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (rst || i == 0) begin
            regs[i] <= '0;
         end else if (wa_en && wa_idx == IW'(i)) begin
            regs[i] <= wa_data;
         end else if (wb_en && wb_idx == IW'(i)) begin
            regs[i] <= wb_data;
         end
      end
   end

   assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
   assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
   assign rc_data = (rc_idx == '0) ? '0 : regs[rc_idx];
endmodule

// File: rtl/rotu_amt_sel.sv
`timescale 1ns/1ps
module rotu_amt_sel #(
   parameter int AW = 4
) (
   input  rotu_pkg::amt_mode_e mode,
   input  logic [AW-1:0]       imm,
   input  logic [AW-1:0]       src_lo,
   output logic [AW-1:0]       amt
);
   always_comb begin
      unique case (mode)
         rotu_pkg::AMT_REG: amt = src_lo;
         default:           amt = imm;
      endcase
   end
endmodule

// File: rtl/rotu_rotator.sv
`timescale 1ns/1ps
module rotu_rotator #(
   parameter int DW        = 16,
   parameter int AW        = $clog2(DW),
   parameter int ROT_STYLE = 0
) (
   input  logic [DW-1:0] din,
   input  logic [AW-1:0] amt,
   output logic [DW-1:0] dout
);
   generate
      if (ROT_STYLE == 0) begin : g_log
         logic [DW-1:0] stage [AW+1];
         assign stage[0] = din;
         for (genvar k = 0; k < AW; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = amt[k]
               ? {stage[k][SH-1:0], stage[k][DW-1:SH]}
               : stage[k];
         end
         assign dout = stage[AW];
      end else begin : g_dbl
         logic [2*DW-1:0] dbl;
         assign dbl  = {din, din} >> amt;
         logic [DW-1:0] unused_top;
         assign unused_top = dbl[2*DW-1:DW];
         assign dout = dbl[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/rotu_ccr.sv
`timescale 1ns/1ps
module rotu_ccr #(
   parameter int DW = 16
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           exec_en,
   input  logic [DW-1:0]                  res,
   input  logic                           ld_en,
   input  logic [rotu_pkg::CCR_W-1:0]     ld_val,
   output logic [rotu_pkg::CCR_W-1:0]     flags
);
   rotu_pkg::ccr_t q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (exec_en) begin
         q.n <= res[DW-1];
         q.z <= (res == '0);
         q.v <= 1'b0;
      end else if (ld_en) begin
         q <= rotu_pkg::ccr_t'(ld_val);
      end
   end

   assign flags = q;
endmodule

// File: rtl/rotu_exec.sv
`timescale 1ns/1ps
module rotu_exec #(
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int ROT_STYLE = 0,
   localparam int AW       = $clog2(DW),
   localparam int IW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          exec_en,
   input  logic          amt_mode,
   input  logic [IW-1:0] dst_idx,
   input  logic [IW-1:0] src_idx,
   input  logic [AW-1:0] imm_amt,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_idx,
   input  logic [DW-1:0] ld_data,
   input  logic          ccr_ld_en,
   input  logic [3:0]    ccr_ld_val,
   input  logic [IW-1:0] obs_idx,
   output logic [DW-1:0] result,
   output logic [3:0]    flags,
   output logic [DW-1:0] obs_data
);
   generate
      if ((1 << AW) != DW) begin : g_bad_dw
         $error("rotu_exec: DW must be a power of two");
      end
      if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_nreg
         $error("rotu_exec: NREG must be a power of two of at least 2");
      end
      if (ROT_STYLE != 0 && ROT_STYLE != 1) begin : g_bad_style
         $error("rotu_exec: ROT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DW-1:0] dst_val;
   logic [DW-1:0] src_val;
   logic [AW-1:0] amt;
   logic [DW-AW-1:0] unused_src_hi;

   assign unused_src_hi = src_val[DW-1:AW];

   rotu_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .ra_idx  (dst_idx),
      .ra_data (dst_val),
      .rb_idx  (src_idx),
      .rb_data (src_val),
      .rc_idx  (obs_idx),
      .rc_data (obs_data),
      .wa_en   (exec_en),
      .wa_idx  (dst_idx),
      .wa_data (result),
      .wb_en   (ld_en),
      .wb_idx  (ld_idx),
      .wb_data (ld_data)
   );

   rotu_amt_sel #(.AW(AW)) u_amt (
      .mode   (rotu_pkg::amt_mode_e'(amt_mode)),
      .imm    (imm_amt),
      .src_lo (src_val[AW-1:0]),
      .amt    (amt)
   );

   rotu_rotator #(.DW(DW), .AW(AW), .ROT_STYLE(ROT_STYLE)) u_rot (
      .din  (dst_val),
      .amt  (amt),
      .dout (result)
   );

   rotu_ccr #(.DW(DW)) u_ccr (
      .clk     (clk),
      .rst     (rst),
      .exec_en (exec_en),
      .res     (result),
      .ld_en   (ccr_ld_en),
      .ld_val  (ccr_ld_val),
      .flags   (flags)
   );
endmodule

// File: rtl/rotu_exec_chk.sv
`timescale 1ns/1ps
module rotu_exec_chk #(
   parameter int DW = 16,
   parameter int IW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          exec_en,
   input logic          ld_en,
   input logic          ccr_ld_en,
   input logic [DW-1:0] result,
   input logic [3:0]    flags,
   input logic [IW-1:0] obs_idx,
   input logic [DW-1:0] obs_data
);
   AST_N_TRACKS_MSB: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> flags[3] == $past(result[DW-1])); // R5
   AST_Z_TRACKS_ZERO: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> flags[2] == ($past(result) == '0)); // R6
   AST_V_CLEARED: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> !flags[1]); // R7
   AST_C_KEPT: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> flags[0] == $past(flags[0])); // R8
   AST_REG0_ZERO: assert property (@(posedge clk) disable iff (rst)
      (obs_idx == '0) |-> (obs_data == '0)); // R9
   AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (!exec_en && !ld_en && !ccr_ld_en) |=> $stable(flags)); // R10
endmodule

bind rotu_exec rotu_exec_chk #(.DW(DW), .IW(IW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .exec_en   (exec_en),
   .ld_en     (ld_en),
   .ccr_ld_en (ccr_ld_en),
   .result    (result),
   .flags     (flags),
   .obs_idx   (obs_idx),
   .obs_data  (obs_data)
);

// File: tb/tb_rotu_exec.sv
`timescale 1ns/1ps
module tb_rotu_exec;
   logic        clk = 1'b0;
   logic        rst;
   logic        exec_en, amt_mode, ld_en, ccr_ld_en;
   logic [2:0]  dst_idx, src_idx, ld_idx, obs_idx;
   logic [3:0]  imm_amt, ccr_ld_val, flags;
   logic [15:0] ld_data, result, obs_data;

   int checks = 0;
   int errors = 0;
   logic exp_c = 1'b0;

   always #10 clk = ~clk;

   rotu_exec dut (
      .clk(clk), .rst(rst), .exec_en(exec_en), .amt_mode(amt_mode),
      .dst_idx(dst_idx), .src_idx(src_idx), .imm_amt(imm_amt),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .ccr_ld_en(ccr_ld_en), .ccr_ld_val(ccr_ld_val), .obs_idx(obs_idx),
      .result(result), .flags(flags), .obs_data(obs_data)
   );

   function automatic logic [15:0] rotr(input logic [15:0] v, input int n);
      logic [15:0] lo, hi;
      lo = v >> n;
      hi = (n == 0) ? 16'h0 : (v << (16 - n));
      return lo | hi;
   endfunction

   function automatic logic [3:0] exp_flags(input logic [15:0] r, input logic c);
      return {r[15], (r == 16'h0), 1'b0, c};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic load(input logic [2:0] idx, input logic [15:0] val);
      ld_en = 1'b1; ld_idx = idx; ld_data = val;
      tick();
      ld_en = 1'b0;
   endtask

   task automatic peek(input string req, input logic [2:0] idx, input logic [15:0] exp);
      obs_idx = idx;
      #1;
      chk(req, obs_data, exp);
   endtask

   // rotate register dst; checks the combinational result, the write-back and the flags
   task automatic run(input string req, input logic mode, input logic [2:0] dst,
                      input logic [2:0] src, input logic [3:0] imm,
                      input logic [15:0] dval, input int n);
      logic [15:0] er;
      er = (dst == 3'd0) ? 16'h0 : rotr(dval, n);
      amt_mode = mode; dst_idx = dst; src_idx = src; imm_amt = imm;
      exec_en = 1'b1;
      #2;
      chk({req, " result"}, result, er);
      tick();
      exec_en = 1'b0;
      peek({req, " writeback"}, dst, er);
      chk({req, " R5 R6 R7 R8 flags"}, {12'h0, flags}, {12'h0, exp_flags(er, exp_c)});
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] pats [6];
      pats[0] = 16'h8001; pats[1] = 16'h1234; pats[2] = 16'hF0F0;
      pats[3] = 16'h0001; pats[4] = 16'hA5C3; pats[5] = 16'h0000;
      rst = 1'b1; exec_en = 0; amt_mode = 0; ld_en = 0; ccr_ld_en = 0;
      dst_idx = 0; src_idx = 0; imm_amt = 0; ld_idx = 0; ld_data = 0;
      ccr_ld_val = 0; obs_idx = 0;
      tick(); tick();
      rst = 1'b0;
      // R11 reset state
      chk("R11 flags after reset", {12'h0, flags}, 16'h0);
      for (int i = 0; i < 8; i++) peek("R11 reg after reset", 3'(i), 16'h0);

      // R1 R2 R4: immediate mode, every amount, several patterns
      for (int p = 0; p < 6; p++) begin
         for (int n = 0; n < 16; n++) begin
            load(3'd3, pats[p]);
            run((n == 0) ? "R4 R2 R1 imm" : "R2 R1 imm", 1'b0, 3'd3, 3'd1, 4'(n), pats[p], n);
         end
      end

      // R8: C set by the flag load survives executes
      ccr_ld_en = 1'b1; ccr_ld_val = 4'b0111;
      tick();
      ccr_ld_en = 1'b0;
      exp_c = 1'b1;
      chk("R12 flag load", {12'h0, flags}, 16'h0007);

      // R3: register mode, upper source bits vary
      for (int p = 0; p < 5; p++) begin
         for (int n = 0; n < 16; n++) begin
            logic [15:0] sv;
            sv = {12'(n * 16'h0537 + p * 16'h0bad), 4'(n)};
            load(3'd5, sv);
            load(3'd2, pats[p]);
            imm_amt = 4'(15 - n);
            run("R3 reg mode", 1'b1, 3'd2, 3'd5, 4'(15 - n), pats[p], n);
         end
      end

      // R3: src == dst, amount from its own nibble
      load(3'd4, 16'hC3A6);
      run("R3 self source", 1'b1, 3'd4, 3'd4, 4'd0, 16'hC3A6, 6);

      // R10: idle edges change nothing
      load(3'd6, 16'h1357);
      amt_mode = 0; dst_idx = 3'd6; imm_amt = 4'd5;
      begin
         logic [3:0] fprev;
         fprev = flags;
         tick(); tick();
         peek("R10 idle reg", 3'd6, 16'h1357);
         chk("R10 idle flags", {12'h0, flags}, {12'h0, fprev});
      end

      // R9: register 0
      load(3'd0, 16'hFFFF);
      peek("R9 reg0 load ignored", 3'd0, 16'h0);
      run("R9 reg0 exec", 1'b0, 3'd0, 3'd0, 4'd3, 16'h0, 3);
      peek("R9 reg0 after exec", 3'd0, 16'h0);

      // R12: execute beats load on same register; flag load ignored during execute
      load(3'd7, 16'h0003);
      ld_en = 1'b1; ld_idx = 3'd7; ld_data = 16'hDEAD;
      ccr_ld_en = 1'b1; ccr_ld_val = 4'b1110;
      run("R12 exec priority", 1'b0, 3'd7, 3'd0, 4'd1, 16'h0003, 1);
      ld_en = 1'b0; ccr_ld_en = 1'b0;
      // R12: load to a different register in the same cycle still lands
      ld_en = 1'b1; ld_idx = 3'd1; ld_data = 16'h4242;
      run("R12 parallel exec", 1'b0, 3'd7, 3'd0, 4'd2, rotr(16'h0003, 1), 2);
      ld_en = 1'b0;
      peek("R12 parallel load", 3'd1, 16'h4242);

      // R11: reset mid-run
      rst = 1'b1;
      tick();
      rst = 1'b0;
      exp_c = 1'b0;
      chk("R11 flags after late reset", {12'h0, flags}, 16'h0);
      peek("R11 reg after late reset", 3'd7, 16'h0);
      peek("R11 reg1 after late reset", 3'd1, 16'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule